// File: doc/BRIEF.md
# Per-Core Inter-Processor Event Multiplexer

This block lets every core of a small cluster receive up to 32 distinct inter-processor events while it has only one physical interrupt line from the block. Any core may post an event number to a set of target cores. The block records the event as one bit in each target's 32-bit pending register and holds that target's interrupt line high. The interrupted core reads its pending word, treats every set bit as its own interrupt, and acknowledges the bits it handled by writing ones to them. A second line per core carries events that a core raises toward itself. It has its own pending word and its own acknowledge.

Every core has a private register port with a valid/ready handshake, so all cores can post, acknowledge and read in the same cycle. Posts that land in the same cycle are merged. A post and an acknowledge of the same bit in the same cycle leave the bit set, so no event is lost to a race. A per-core enable mask gates both lines without discarding pending bits.

Top module: `ipi_event_mux`

## Requirements
- R1: After reset every pending word and self-pending word is zero, every enable mask reads 0xFFFFFFFF, every ipi_irq and self_irq output is low, and rd_valid is low.
- R2: A write to address 0 from any port posts event wdata[12:8] to each core c for which wdata[c] is 1. The bit is visible in core c's pending word from the next cycle. Mask bits at positions NUM_CORES and above are ignored.
- R3: ipi_irq[c] is high exactly while core c's pending word ANDed with its enable mask is nonzero. It follows a post or an acknowledge in the cycle after the write.
- R4: A write to address 1 from port c clears each bit of core c's pending word whose wdata bit is 1. Bits written as 0 are unchanged.
- R5: When a bit is posted and acknowledged in the same cycle, it is set afterwards. Other acknowledged bits are still cleared.
- R6: Posts from several ports in the same cycle are ORed into each target's pending word, including two posts of the same event.
- R7: Address 2 is port c's enable mask (read/write, 1 = delivered). A cleared mask bit holds ipi_irq and self_irq low for that event, and the pending bit is kept.
- R8: A write to address 3 from port c sets bit wdata[4:0] of core c's self-pending word and leaves its pending word unchanged. self_irq[c] is high exactly while the self-pending word ANDed with the mask is nonzero. Address 4 reads the self-pending word and clears it write-one-to-clear.
- R9: A read accepted in cycle t gives rd_valid high with rd_data in cycle t+1. The data is the register value before any update made in cycle t. Addresses 0 and 3 and unmapped addresses 5 to 7 read 0. Writes to addresses 5 to 7 change nothing.
- R10: bus_ready is high on every port in every cycle after reset, so each request is taken in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | NUM_CORES | Request valid, one per core port |
| bus_write | input | NUM_CORES | 1 = write, 0 = read |
| bus_addr | input | NUM_CORES x 3 | Register address per port |
| bus_wdata | input | NUM_CORES x 32 | Write data per port |
| bus_ready | output | NUM_CORES | Request accepted |
| rd_valid | output | NUM_CORES | Read data valid (one cycle after the read) |
| rd_data | output | NUM_CORES x 32 | Read data per port |
| ipi_irq | output | NUM_CORES | Level interrupt for events from other cores |
| self_irq | output | NUM_CORES | Level interrupt for self-raised events |

## Verification
Two functions meet in one cycle: a post aimed at a core, and that core's write-one-to-clear of the same pending word. The bench provokes this by driving one port's post and the target port's acknowledge on the same clock edge. One acknowledged bit is also being posted and another is not. The result is judged by reading the pending word back and checking the line, which must show the posted bit set and the other bit cleared. A second collision, several ports posting to one target together, is judged the same way against the OR of the events.

// File: rtl/ipi_mux_pkg.sv
package ipi_mux_pkg;
  localparam int EVT_W     = 32;
  localparam int EVT_IDX_W = $clog2(EVT_W);
  localparam int ADDR_W    = 3;
  localparam int MAX_CORES = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_POST      = 3'd0,
    A_PEND      = 3'd1,
    A_MASK      = 3'd2,
    A_SELF_POST = 3'd3,
    A_SELF_PEND = 3'd4
  } reg_addr_e;

  // one-hot of an event index
  function automatic logic [EVT_W-1:0] evt_bit(input logic [EVT_IDX_W-1:0] idx);
    logic [EVT_W-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  // next pending word: acknowledges drop bits, posts (winning) add bits
  function automatic logic [EVT_W-1:0] pend_next(input logic [EVT_W-1:0] cur,
                                                 input logic [EVT_W-1:0] set_v,
                                                 input logic [EVT_W-1:0] clr_v);
    return (cur & ~clr_v) | set_v;
  endfunction
endpackage

// File: rtl/ipi_port_decode.sv
module ipi_port_decode
  import ipi_mux_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [EVT_W-1:0]      req_wdata,
  output logic [NUM_CORES-1:0]  post_tgt,
  output logic [EVT_W-1:0]      post_evt,
  output logic [EVT_W-1:0]      pend_clr,
  output logic [EVT_W-1:0]      self_set,
  output logic [EVT_W-1:0]      self_clr,
  output logic                  mask_we
);
  logic wr_en;
  assign wr_en = req_valid & req_write;

  always_comb begin
    post_tgt = '0;
    post_evt = '0;
    pend_clr = '0;
    self_set = '0;
    self_clr = '0;
    mask_we  = 1'b0;
    if (wr_en) begin
      case (req_addr)
        A_POST: begin
          post_tgt = req_wdata[NUM_CORES-1:0];
          post_evt = evt_bit(req_wdata[8 +: EVT_IDX_W]);
        end
        A_PEND:      pend_clr = req_wdata;
        A_MASK:      mask_we  = 1'b1;
        A_SELF_POST: self_set = evt_bit(req_wdata[EVT_IDX_W-1:0]);
        A_SELF_PEND: self_clr = req_wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ipi_set_merge.sv
module ipi_set_merge
  import ipi_mux_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic [NUM_CORES-1:0][NUM_CORES-1:0] src_tgt,
  input  logic [NUM_CORES-1:0][EVT_W-1:0]     src_evt,
  output logic [NUM_CORES-1:0][EVT_W-1:0]     dst_set
);
  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      dst_set[c] = '0;
      for (int s = 0; s < NUM_CORES; s++) begin
        if (src_tgt[s][c]) dst_set[c] = dst_set[c] | src_evt[s];
      end
    end
  end
endmodule

// File: rtl/ipi_pend_bank.sv
module ipi_pend_bank
  import ipi_mux_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] set_v,
  input  logic [EVT_W-1:0] clr_v,
  output logic [EVT_W-1:0] pend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_next(pend_q, set_v, clr_v);
  end

  // R2/R5: every posted bit is present next cycle, even if also acknowledged
  p_post_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v != '0) |=> ((pend_q & $past(set_v)) == $past(set_v)));

  // R4: acknowledged bits that were not posted are gone next cycle
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_v != '0) |=> ((pend_q & $past(clr_v) & ~$past(set_v)) == '0));

  // R5: no pending bit vanishes without an acknowledge
  p_no_loss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q) & ~$past(clr_v) & ~pend_q) == '0));

  // R2: no bit appears without a post
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(set_v)) == '0));
endmodule

// File: rtl/ipi_event_mux.sv
module ipi_event_mux
  import ipi_mux_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_CORES-1:0]              bus_valid,
  input  logic [NUM_CORES-1:0]              bus_write,
  input  logic [NUM_CORES-1:0][ADDR_W-1:0]  bus_addr,
  input  logic [NUM_CORES-1:0][EVT_W-1:0]   bus_wdata,
  output logic [NUM_CORES-1:0]              bus_ready,
  output logic [NUM_CORES-1:0]              rd_valid,
  output logic [NUM_CORES-1:0][EVT_W-1:0]   rd_data,
  output logic [NUM_CORES-1:0]              ipi_irq,
  output logic [NUM_CORES-1:0]              self_irq
);
  // named internal events for the assertions
  logic [NUM_CORES-1:0][NUM_CORES-1:0] post_tgt;
  logic [NUM_CORES-1:0][EVT_W-1:0]     post_evt;
  logic [NUM_CORES-1:0][EVT_W-1:0]     pend_clr;
  logic [NUM_CORES-1:0][EVT_W-1:0]     self_set;
  logic [NUM_CORES-1:0][EVT_W-1:0]     self_clr;
  logic [NUM_CORES-1:0]                mask_we;
  logic [NUM_CORES-1:0][EVT_W-1:0]     merged_set;
  logic [NUM_CORES-1:0][EVT_W-1:0]     pend_q;
  logic [NUM_CORES-1:0][EVT_W-1:0]     spend_q;
  logic [NUM_CORES-1:0][EVT_W-1:0]     mask_q;
  logic [NUM_CORES-1:0]                rd_take;
  logic [NUM_CORES-1:0][EVT_W-1:0]     rd_next;

  assign bus_ready = '1;

  ipi_set_merge #(.NUM_CORES(NUM_CORES)) u_merge (
    .src_tgt (post_tgt),
    .src_evt (post_evt),
    .dst_set (merged_set)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    ipi_port_decode #(.NUM_CORES(NUM_CORES)) u_dec (
      .req_valid (bus_valid[c]),
      .req_write (bus_write[c]),
      .req_addr  (bus_addr[c]),
      .req_wdata (bus_wdata[c]),
      .post_tgt  (post_tgt[c]),
      .post_evt  (post_evt[c]),
      .pend_clr  (pend_clr[c]),
      .self_set  (self_set[c]),
      .self_clr  (self_clr[c]),
      .mask_we   (mask_we[c])
    );

    ipi_pend_bank u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_v  (merged_set[c]),
      .clr_v  (pend_clr[c]),
      .pend_q (pend_q[c])
    );

    ipi_pend_bank u_self (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_v  (self_set[c]),
      .clr_v  (self_clr[c]),
      .pend_q (spend_q[c])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mask_q[c] <= '1;
      else if (mask_we[c]) mask_q[c] <= bus_wdata[c];
    end

    assign ipi_irq[c]  = |(pend_q[c]  & mask_q[c]);
    assign self_irq[c] = |(spend_q[c] & mask_q[c]);

    assign rd_take[c] = bus_valid[c] & ~bus_write[c];

    always_comb begin
      case (bus_addr[c])
        A_PEND:      rd_next[c] = pend_q[c];
        A_MASK:      rd_next[c] = mask_q[c];
        A_SELF_PEND: rd_next[c] = spend_q[c];
        default:     rd_next[c] = '0;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_valid[c] <= 1'b0;
        rd_data[c]  <= '0;
      end else begin
        rd_valid[c] <= rd_take[c];
        if (rd_take[c]) rd_data[c] <= rd_next[c];
      end
    end

    // R7: a fully closed mask keeps both lines low
    p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q[c] == '0) |-> (!ipi_irq[c] && !self_irq[c]));

    // R9: an accepted read returns data in the next cycle
    p_read_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid[c] && !bus_write[c]) |=> rd_valid[c]);

    // R8: a self post never touches the cross-core pending word
    p_self_isolated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (merged_set[c] == '0 && pend_clr[c] == '0) |=> $stable(pend_q[c]));

    // R3: a pending word that stays empty keeps the line low
    p_line_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[c] == '0) |-> !ipi_irq[c]);
  end
endmodule

// File: tb/ipi_event_mux_tb_top.sv
module ipi_event_mux_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]           bus_valid = '0;
  logic [N-1:0]           bus_write = '0;
  logic [N-1:0][2:0]      bus_addr  = '0;
  logic [N-1:0][31:0]     bus_wdata = '0;
  logic [N-1:0]           bus_ready;
  logic [N-1:0]           rd_valid;
  logic [N-1:0][31:0]     rd_data;
  logic [N-1:0]           ipi_irq;
  logic [N-1:0]           self_irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_event_mux #(.NUM_CORES(N)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .ipi_irq(ipi_irq), .self_irq(self_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // stage a request on one port (no clock)
  task automatic put(input int p, input logic w, input logic [2:0] a, input logic [31:0] d);
    bus_valid[p] = 1'b1;
    bus_write[p] = w;
    bus_addr[p]  = a;
    bus_wdata[p] = d;
  endtask

  // let staged requests take one edge, then release the bus
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    bus_valid = '0;
    bus_write = '0;
  endtask

  task automatic wr(input int p, input logic [2:0] a, input logic [31:0] d);
    put(p, 1'b1, a, d);
    step();
  endtask

  task automatic rd(input int p, input logic [2:0] a, output logic [31:0] d, input string tag);
    put(p, 1'b0, a, 32'h0);
    step();
    chk({tag, " rd_valid"}, {31'b0, rd_valid[p]}, 32'h1);
    d = rd_data[p];
  endtask

  task automatic clear_all();
    for (int c = 0; c < N; c++) begin
      put(c, 1'b1, 3'd1, 32'hFFFF_FFFF);
    end
    step();
    for (int c = 0; c < N; c++) begin
      put(c, 1'b1, 3'd4, 32'hFFFF_FFFF);
    end
    step();
  endtask

  function automatic logic [31:0] post_word(input logic [7:0] tmask, input int evt);
    return {19'b0, evt[4:0], tmask};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 ipi_irq", {28'b0, ipi_irq}, 32'h0);
    chk("R1 self_irq", {28'b0, self_irq}, 32'h0);
    chk("R1 rd_valid", {28'b0, rd_valid}, 32'h0);
    chk("R10 ready", {28'b0, bus_ready}, 32'hF);
    rd(2, 3'd1, v, "R1 pend");  chk("R1 pend", v, 32'h0);
    rd(3, 3'd2, v, "R1 mask");  chk("R1 mask", v, 32'hFFFF_FFFF);
    rd(1, 3'd4, v, "R1 spend"); chk("R1 self pend", v, 32'h0);
  endtask

  task automatic t_post();
    logic [31:0] v;
    wr(0, 3'd0, post_word(8'b0110, 5));
    chk("R3 lines after post", {28'b0, ipi_irq}, 32'h6);
    rd(1, 3'd1, v, "R2"); chk("R2 core1 pend", v, 32'h20);
    rd(2, 3'd1, v, "R2"); chk("R2 core2 pend", v, 32'h20);
    rd(0, 3'd1, v, "R2"); chk("R2 untargeted core0", v, 32'h0);
    clear_all();
    wr(1, 3'd0, post_word(8'hF8, 31));
    chk("R2 high mask bits ignored", {28'b0, ipi_irq}, 32'h8);
    rd(3, 3'd1, v, "R2"); chk("R2 core3 bit31", v, 32'h8000_0000);
    clear_all();
  endtask

  task automatic t_ack();
    logic [31:0] v;
    wr(0, 3'd0, post_word(8'b0100, 3));
    wr(0, 3'd0, post_word(8'b0100, 9));
    wr(2, 3'd1, 32'h0);
    rd(2, 3'd1, v, "R4"); chk("R4 zero write keeps bits", v, 32'h208);
    wr(2, 3'd1, 32'h8);
    rd(2, 3'd1, v, "R4"); chk("R4 partial ack", v, 32'h200);
    chk("R3 line stays with bit left", {31'b0, ipi_irq[2]}, 32'h1);
    wr(2, 3'd1, 32'h200);
    chk("R3 line drops after last ack", {31'b0, ipi_irq[2]}, 32'h0);
    clear_all();
  endtask

  task automatic t_race();
    logic [31:0] v;
    wr(3, 3'd0, post_word(8'b0100, 5));
    wr(3, 3'd0, post_word(8'b0100, 6));
    put(3, 1'b1, 3'd0, post_word(8'b0100, 5));
    put(2, 1'b1, 3'd1, 32'h60);
    step();
    rd(2, 3'd1, v, "R5"); chk("R5 post beats ack", v, 32'h20);
    chk("R5 line still high", {31'b0, ipi_irq[2]}, 32'h1);
    clear_all();
  endtask

  task automatic t_multi();
    logic [31:0] v;
    put(0, 1'b1, 3'd0, post_word(8'b0010, 1));
    put(2, 1'b1, 3'd0, post_word(8'b0010, 2));
    put(3, 1'b1, 3'd0, post_word(8'b1010, 1));
    step();
    rd(1, 3'd1, v, "R6"); chk("R6 merged posts core1", v, 32'h6);
    rd(3, 3'd1, v, "R6"); chk("R6 merged posts core3", v, 32'h2);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(1, 3'd2, 32'h0);
    chk("R7 masked line low", {31'b0, ipi_irq[1]}, 32'h0);
    rd(1, 3'd1, v, "R7"); chk("R7 pending kept", v, 32'h6);
    rd(1, 3'd2, v, "R7"); chk("R7 mask readback", v, 32'h0);
    wr(1, 3'd2, 32'h4);
    chk("R7 partial mask passes bit2", {31'b0, ipi_irq[1]}, 32'h1);
    wr(1, 3'd2, 32'h1);
    chk("R7 mask on other bit", {31'b0, ipi_irq[1]}, 32'h0);
    wr(1, 3'd2, 32'hFFFF_FFFF);
    chk("R7 unmask restores line", {31'b0, ipi_irq[1]}, 32'h1);
    clear_all();
  endtask

  task automatic t_self();
    logic [31:0] v;
    wr(0, 3'd3, 32'd7);
    chk("R8 self line", {28'b0, self_irq}, 32'h1);
    chk("R8 cross line untouched", {28'b0, ipi_irq}, 32'h0);
    rd(0, 3'd4, v, "R8"); chk("R8 self pend", v, 32'h80);
    rd(0, 3'd1, v, "R8"); chk("R8 pend untouched", v, 32'h0);
    wr(0, 3'd2, 32'h0);
    chk("R8 self masked", {31'b0, self_irq[0]}, 32'h0);
    wr(0, 3'd2, 32'hFFFF_FFFF);
    wr(0, 3'd4, 32'h80);
    chk("R8 self ack", {31'b0, self_irq[0]}, 32'h0);
  endtask

  task automatic t_read();
    logic [31:0] v;
    wr(0, 3'd0, post_word(8'b0010, 4));
    put(1, 1'b0, 3'd1, 32'h0);
    put(0, 1'b1, 3'd0, post_word(8'b0010, 8));
    step();
    chk("R9 read shows pre-update", rd_data[1], 32'h10);
    rd(1, 3'd1, v, "R9"); chk("R9 next read updated", v, 32'h110);
    wr(1, 3'd6, 32'hFFFF_FFFF);
    wr(1, 3'd5, 32'hFFFF_FFFF);
    rd(1, 3'd1, v, "R9"); chk("R9 unmapped write ignored", v, 32'h110);
    rd(1, 3'd2, v, "R9"); chk("R9 mask after unmapped write", v, 32'hFFFF_FFFF);
    rd(1, 3'd7, v, "R9"); chk("R9 unmapped reads 0", v, 32'h0);
    rd(1, 3'd0, v, "R9"); chk("R9 post addr reads 0", v, 32'h0);
    step();
    chk("R9 rd_valid falls", {31'b0, rd_valid[1]}, 32'h0);
    chk("R10 ready", {28'b0, bus_ready}, 32'hF);
    clear_all();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_post();
    t_ack();
    t_race();
    t_multi();
    t_mask();
    t_self();
    t_read();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule